// File: doc/BRIEF.md
# Program Address Sequencer with Return Stack

This block keeps the fetch address for a 512-word program store of 14-bit instruction words. Each cycle it looks at the instruction word being executed. Branch-class words redirect the address: long and short calls, long jumps, jumps, a plain return, and a return that also hands back an 8-bit literal. An ALU write to the low program-counter byte and a skip request from a bit-test instruction also change the flow. The block holds return addresses in a small stack that is two entries deep by default.

The address runs one word ahead of execution. Every redirect therefore leaves one already-fetched word that must be discarded. The block marks that cycle with `flush`, so surrounding logic treats the word as a no-op. A skip uses the same mechanism to discard the word that follows the test instruction. The ALU, program store and register file live outside this block.

Top module: `pc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next fetch address is 0x1FF, `flush` is low and no stack effect takes place. The stack entries clear to 0.
- R2: With no flush, no branch word, `pc_wr` low and `skip_req` low, the fetch address rises by 1 each cycle and `flush` stays low. After 0x1FF the address wraps to 0x000.
- R3: A long jump word `1010` followed by a 10-bit field loads the field's low 9 bits as the next fetch address. Field bit 9 is ignored.
- R4: A long call word `1000` followed by a 10-bit field loads the same 9-bit target. It pushes the return address, which is the fetch address present in the call's cycle (the call's own address plus 1).
- R5: A short call word `110000` followed by 8 bits loads those 8 bits with the upper address bit forced to 0, and pushes the return address as in R4.
- R6: A jump word `11001` followed by 9 bits loads those 9 bits as the next fetch address.
- R7: The return word 0x1004 and a return-with-literal word `110001` followed by 8 bits both load the newest stack entry and pop it.
- R8: With `pc_wr` high, the next fetch address is `{0, alu_data}`. A branch word in the same cycle wins over `pc_wr`.
- R9: Every taken branch or PC write raises `flush` for exactly the next cycle. In a flush cycle, the instruction word, `pc_wr` and `skip_req` are ignored, the stack is untouched, and the address rises by 1.
- R10: `skip_req` in a cycle with no branch and no PC write raises `flush` for the next cycle while the address keeps counting. The word following the test instruction is thereby discarded.
- R11: A third push discards the oldest entry. A pop from an emptied stack returns the last value popped again.
- R12: `lit_valid` is high, in the same cycle, only for a return-with-literal word outside a flush cycle. `lit_data` then carries the word's low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 14 | Instruction word executing this cycle |
| pc_wr | input | 1 | ALU result is written to the PC low byte |
| alu_data | input | 8 | ALU result byte |
| skip_req | input | 1 | Test instruction resolved to skip |
| fetch_addr | output | 9 | Program store address |
| flush | output | 1 | Word executing this cycle is discarded |
| lit_valid | output | 1 | Load literal into working register |
| lit_data | output | 8 | Literal from return-with-literal word |

## Verification
The bench builds the block with its defaults: a 9-bit address and a two-entry stack. At that size, every value of every branch field can be swept outright. All 1024 long-jump fields are driven, which shows that field bit 9 is dropped. Every 9-bit jump target, every short-call byte paired with its return, every ALU byte and every literal value are also covered. The small stack makes overflow and underflow reachable in a handful of calls, and the 512-word space lets a free-running count wrap in a few hundred cycles.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int INSTR_W = 14;
    localparam int DATA_W  = 8;
    localparam int FIELD_W = 10;

    localparam logic [INSTR_W-1:0] RET_WORD = 14'h1004;

    typedef enum logic [1:0] {
        SRC_LONG,
        SRC_NINE,
        SRC_BYTE,
        SRC_STACK
    } tgt_src_e;

    typedef struct packed {
        logic               taken;
        logic               push;
        logic               pop;
        logic               lit;
        tgt_src_e           src;
        logic [FIELD_W-1:0] fld;
    } br_ctl_t;

    function automatic br_ctl_t classify(input logic [INSTR_W-1:0] w);
        br_ctl_t c;
        c       = '0;
        c.src   = SRC_LONG;
        c.fld   = w[FIELD_W-1:0];
        if (w[13:10] == 4'b1010) begin
            c.taken = 1'b1;
        end else if (w[13:10] == 4'b1000) begin
            c.taken = 1'b1;
            c.push  = 1'b1;
        end else if (w[13:8] == 6'b110000) begin
            c.taken = 1'b1;
            c.push  = 1'b1;
            c.src   = SRC_BYTE;
        end else if (w[13:8] == 6'b110001) begin
            c.taken = 1'b1;
            c.pop   = 1'b1;
            c.lit   = 1'b1;
            c.src   = SRC_STACK;
        end else if (w[13:9] == 5'b11001) begin
            c.taken = 1'b1;
            c.src   = SRC_NINE;
        end else if (w == RET_WORD) begin
            c.taken = 1'b1;
            c.pop   = 1'b1;
            c.src   = SRC_STACK;
        end
        return c;
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output br_ctl_t            ctl
);

    always_comb begin
        ctl = classify(instr);
    end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);

    logic [W-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)       entry[i] <= '0;
                else if (push) entry[i] <= din;
                else if (pop)  entry[i] <= entry[i+1];
            end
        end else if (i == DEPTH - 1) begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)       entry[i] <= '0;
                else if (push) entry[i] <= entry[i-1];
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)       entry[i] <= '0;
                else if (push) entry[i] <= entry[i-1];
                else if (pop)  entry[i] <= entry[i+1];
            end
        end
    end

    assign top = entry[0];

    // R11: a pushed value becomes the newest entry
    assert_push_top_R11: assert property (@(posedge clk) disable iff (rst)
        push |=> (top == $past(din)));

endmodule

// File: rtl/pc_seq.sv
module pc_seq
    import pcs_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               pc_wr,
    input  logic [DATA_W-1:0]  alu_data,
    input  logic               skip_req,
    output logic [PC_W-1:0]    fetch_addr,
    output logic               flush,
    output logic               lit_valid,
    output logic [DATA_W-1:0]  lit_data
);

    localparam logic [PC_W-1:0] RESET_PC = '1;

    br_ctl_t         ctl;
    logic [PC_W-1:0] pc_q, pc_n, target, stk_top;
    logic            flush_q, flush_n, live;

    pcs_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    assign live = !flush_q;

    pcs_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stk (
        .clk  (clk),
        .rst  (rst),
        .push (live && ctl.push),
        .pop  (live && ctl.pop),
        .din  (pc_q),
        .top  (stk_top)
    );

    always_comb begin
        unique case (ctl.src)
            SRC_LONG:  target = PC_W'(ctl.fld);
            SRC_NINE:  target = PC_W'(ctl.fld[8:0]);
            SRC_BYTE:  target = PC_W'(ctl.fld[7:0]);
            default:   target = stk_top;
        endcase
    end

    always_comb begin
        pc_n    = pc_q + 1'b1;
        flush_n = 1'b0;
        if (live) begin
            if (ctl.taken) begin
                pc_n    = target;
                flush_n = 1'b1;
            end else if (pc_wr) begin
                pc_n    = PC_W'(alu_data);
                flush_n = 1'b1;
            end else if (skip_req) begin
                flush_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_PC;
            flush_q <= 1'b0;
        end else begin
            pc_q    <= pc_n;
            flush_q <= flush_n;
        end
    end

    assign fetch_addr = pc_q;
    assign flush      = flush_q;
    assign lit_valid  = live && ctl.lit;
    assign lit_data   = ctl.fld[DATA_W-1:0];

    assert_reset_vector_R1: assert property (@(posedge clk)
        rst |=> (fetch_addr == RESET_PC) && !flush);

    assert_seq_count_R2: assert property (@(posedge clk) disable iff (rst)
        (!flush && !ctl.taken && !pc_wr && !skip_req)
        |=> !flush && (fetch_addr == PC_W'($past(fetch_addr) + 1'b1)));

    assert_alu_write_R8: assert property (@(posedge clk) disable iff (rst)
        (!flush && !ctl.taken && pc_wr) |=> (fetch_addr == PC_W'($past(alu_data))));

    assert_flush_after_branch_R9: assert property (@(posedge clk) disable iff (rst)
        (!flush && ctl.taken) |=> flush);

    assert_flush_single_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush && (fetch_addr == PC_W'($past(fetch_addr) + 1'b1)));

    assert_skip_flush_R10: assert property (@(posedge clk) disable iff (rst)
        (!flush && !ctl.taken && !pc_wr && skip_req) |=> flush);

endmodule

// File: tb/sim_pc_seq.sv
module sim_pc_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] instr = 14'h1000;
    logic        pc_wr = 1'b0;
    logic [7:0]  alu_data = 8'h00;
    logic        skip_req = 1'b0;
    logic [8:0]  fetch_addr;
    logic        flush;
    logic        lit_valid;
    logic [7:0]  lit_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [8:0] m_pc = 9'h1FF;
    logic [8:0] m_s0 = 9'h000;
    logic [8:0] m_s1 = 9'h000;
    logic       m_fl = 1'b0;

    localparam logic [13:0] NOP = 14'h1000;
    localparam logic [13:0] RET = 14'h1004;

    always #5 clk = ~clk;

    pc_seq u0 (
        .clk(clk), .rst(rst), .instr(instr), .pc_wr(pc_wr), .alu_data(alu_data),
        .skip_req(skip_req), .fetch_addr(fetch_addr), .flush(flush),
        .lit_valid(lit_valid), .lit_data(lit_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [13:0] w, input logic wr, input logic [7:0] a, input logic sk);
        logic [8:0] ret;
        if (m_fl) begin
            m_pc = m_pc + 9'd1;
            m_fl = 1'b0;
        end else if (w[13:10] == 4'b1010) begin
            m_pc = w[8:0]; m_fl = 1'b1;
        end else if (w[13:10] == 4'b1000) begin
            m_s1 = m_s0; m_s0 = m_pc; m_pc = w[8:0]; m_fl = 1'b1;
        end else if (w[13:8] == 6'b110000) begin
            m_s1 = m_s0; m_s0 = m_pc; m_pc = {1'b0, w[7:0]}; m_fl = 1'b1;
        end else if (w[13:9] == 5'b11001) begin
            m_pc = w[8:0]; m_fl = 1'b1;
        end else if (w[13:8] == 6'b110001 || w == RET) begin
            ret = m_s0; m_s0 = m_s1; m_pc = ret; m_fl = 1'b1;
        end else if (wr) begin
            m_pc = {1'b0, a}; m_fl = 1'b1;
        end else begin
            m_pc = m_pc + 9'd1;
            m_fl = sk;
        end
    endtask

    task automatic step(input logic [13:0] w, input logic wr, input logic [7:0] a,
                        input logic sk, input string tag);
        bit exp_lv;
        instr = w; pc_wr = wr; alu_data = a; skip_req = sk;
        #1;
        exp_lv = !m_fl && (w[13:8] == 6'b110001);
        check(lit_valid == exp_lv, {tag, " R12 lit_valid"}, lit_valid, exp_lv);
        if (exp_lv) check(lit_data == w[7:0], {tag, " R12 lit_data"}, lit_data, w[7:0]);
        model(w, wr, a, sk);
        @(posedge clk); #1;
        check(fetch_addr == m_pc, {tag, " addr"}, fetch_addr, m_pc);
        check(flush == m_fl, {tag, " flush"}, flush, m_fl);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check(fetch_addr == 9'h1FF, "R1 reset addr", fetch_addr, 9'h1FF);
        check(flush == 1'b0, "R1 reset flush", flush, 0);
        check(lit_valid == 1'b0, "R1 reset lit", lit_valid, 0);

        // R2: free count through the wrap
        for (int i = 0; i < 600; i++) step(NOP, 1'b0, 8'h00, 1'b0, "R2 count");

        // R3: every long-jump field, bit 9 dropped
        for (int n = 0; n < 1024; n++) begin
            step({4'b1010, 10'(n)}, 1'b0, 8'h00, 1'b0, "R3 ljump");
            step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush after ljump");
        end

        // R6: every jump target
        for (int n = 0; n < 512; n++) begin
            step({5'b11001, 9'(n)}, 1'b0, 8'h00, 1'b0, "R6 jump");
            step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush after jump");
        end

        // R5 and R7: every short-call byte with a return
        for (int n = 0; n < 256; n++) begin
            step({6'b110000, 8'(n)}, 1'b0, 8'h00, 1'b0, "R5 scall");
            step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush after scall");
            step(RET, 1'b0, 8'h00, 1'b0, "R7 ret");
            step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush after ret");
        end

        // R4, R7, R12: long calls returning with every literal
        for (int n = 0; n < 256; n++) begin
            step({4'b1000, 10'(n * 4 + 3)}, 1'b0, 8'h00, 1'b0, "R4 lcall");
            step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush after lcall");
            step({6'b110001, 8'(n)}, 1'b0, 8'h00, 1'b0, "R7 retlit");
            step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush after retlit");
        end

        // R8: every ALU byte, then branch beats write
        for (int n = 0; n < 256; n++) begin
            step(NOP, 1'b1, 8'(n), 1'b0, "R8 pc write");
            step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush after write");
        end
        step({5'b11001, 9'h155}, 1'b1, 8'h22, 1'b0, "R8 branch over write");
        step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush");

        // R9: everything ignored in a flush cycle
        step({5'b11001, 9'h0A0}, 1'b0, 8'h00, 1'b0, "R9 jump");
        step({4'b1010, 10'h033}, 1'b1, 8'h44, 1'b1, "R9 ignored branch/write/skip");
        step(NOP, 1'b0, 8'h00, 1'b0, "R9 after ignore");
        step({6'b110000, 8'h10}, 1'b0, 8'h00, 1'b0, "R5 scall");
        step({6'b110001, 8'h5A}, 1'b0, 8'h00, 1'b0, "R12 retlit in flush ignored");
        step(RET, 1'b0, 8'h00, 1'b0, "R9 stack kept through flush");
        step(NOP, 1'b0, 8'h00, 1'b0, "R9 flush");

        // R10: skips, alone and against a write
        for (int n = 0; n < 20; n++) begin
            step(NOP, 1'b0, 8'h00, 1'b1, "R10 skip");
            step(NOP, 1'b0, 8'h00, 1'b0, "R10 skipped word");
        end
        step(NOP, 1'b1, 8'h77, 1'b1, "R10 write beats skip");
        step(NOP, 1'b0, 8'h00, 1'b0, "R10 flush");

        // R11: overflow and underflow
        step({4'b1000, 10'h040}, 1'b0, 8'h00, 1'b0, "R11 call A");
        step(NOP, 1'b0, 8'h00, 1'b0, "R11 flush");
        step({4'b1000, 10'h080}, 1'b0, 8'h00, 1'b0, "R11 call B");
        step(NOP, 1'b0, 8'h00, 1'b0, "R11 flush");
        step({6'b110000, 8'hC0}, 1'b0, 8'h00, 1'b0, "R11 call C");
        step(NOP, 1'b0, 8'h00, 1'b0, "R11 flush");
        for (int k = 0; k < 4; k++) begin
            step(RET, 1'b0, 8'h00, 1'b0, "R11 pop");
            step(NOP, 1'b0, 8'h00, 1'b0, "R11 flush");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule